// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a word-organised scratchpad that is split into 32 independent banks, each one 32 bits wide. A request carries one word address per lane for all 32 lanes of a warp, plus a per-lane active bit. Word address `a` lives in bank `a mod 32`, at row `a / 32` of that bank. Each bank can deliver one word per pass. When several active lanes name different words that land in one bank, the block replays the access over as many passes as that bank needs. Lanes that name the same word share a single fetch, and its value goes to every one of them.

In every pass each bank looks at its still-pending lanes. It fetches the word of the lowest-numbered pending lane and retires that lane together with every other pending lane that asked for the same word. A pass takes two clock cycles. When no lane is left pending, the block raises a one-cycle response pulse. With that pulse it presents the read data of every lane and the conflict degree, which is the number of passes that were used. Writes are not part of this block. After reset the storage holds a fixed, computable image, so readers see deterministic contents.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response pulse. While it is low, `req_valid` and the request fields are ignored, and the requester must hold or retry. The response has no back-pressure: `rsp_valid` is high for exactly one cycle. `rsp_data` and `rsp_degree` stay unchanged until the next request is accepted.

Top module: `spad_serializer`

## Requirements
- R1: Word address `a` is served by bank `a mod 32`. A request in which all active lanes use different banks completes in one pass (degree 1), and the address arithmetic wraps at the top of the 10-bit word space.
- R2: `rsp_degree` equals the largest number of distinct words that the active lanes map to any single bank. This is at most 32, and at least 1 when some lane is active.
- R3: Every active lane receives the word stored at its address. Lanes sharing a word are served in the same pass by one fetch.
- R4: The response pulse comes exactly 2·D+1 clock edges after the accepting edge, where D is the conflict degree (two cycles per pass plus one completion cycle).
- R5: Lanes whose active bit is 0 return all-zero data in `rsp_data`.
- R6: `req_ready` falls on the edge after a request is accepted and stays low until the response cycle. Requests presented while it is low are ignored and do not change the response.
- R7: After reset the word at address `a` holds `(a × 0x9E3779B1 mod 2^32) XOR 0x5A5A0000`. Lane `i` data sits at `rsp_data[32·i +: 32]`, and lane `i` address sits at `req_addr[10·i +: 10]`.
- R8: During and right after reset, `req_ready` is 1, `rsp_valid` is 0 and `rsp_data` is all zero.
- R9: A request with no active lane completes with degree 0, one edge after acceptance.
- R10: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_active | input | 32 | Per-lane active bit |
| req_addr | input | 320 | Per-lane 10-bit word address, lane i at bits 10·i +: 10 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_degree | output | 6 | Passes used (conflict degree) |
| rsp_data | output | 1024 | Per-lane 32-bit read data, lane i at bits 32·i +: 32 |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks, 10-bit word addresses and two cycles per pass. With these values the worst case of 32 distinct words in one bank (degree 32) can be reached, as can the wrap of addresses past word 1023. The same values also allow mixes of broadcast lanes and conflicting lanes within one bank, such as the degree-17 and degree-8 patterns. Strides of 1, 2, 4, 16, 32, 33 and 64 each produce a known degree, so pass count, latency and per-lane data can all be predicted from address arithmetic alone.

// File: rtl/spad_pkg.sv
package spad_pkg;
  parameter int WORD_W = 32;
  localparam logic [31:0] MIX_MUL = 32'h9E3779B1;
  localparam logic [31:0] MIX_XOR = 32'h5A5A0000;

  typedef enum logic {S_IDLE, S_BUSY} ser_state_e;

  // Deterministic reset image of the storage
  function automatic logic [WORD_W-1:0] image_word(input logic [31:0] a);
    logic [31:0] p;
    p = a * MIX_MUL;
    return WORD_W'(p ^ MIX_XOR);
  endfunction
endpackage

// File: rtl/spad_degree.sv
module spad_degree #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  localparam int BW    = $clog2(BANKS),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]        act,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]        degree
);
  logic [LANES-1:0] first;
  logic [CNT_W-1:0] cnt;

  // A lane is "first" when no lower active lane names the same word
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      first[l] = act[l];
      for (int j = 0; j < l; j++)
        if (act[j] && addr[j*ADDR_W +: ADDR_W] == addr[l*ADDR_W +: ADDR_W])
          first[l] = 1'b0;
    end
  end

  always_comb begin
    degree = '0;
    cnt    = '0;
    for (int b = 0; b < BANKS; b++) begin
      cnt = '0;
      for (int l = 0; l < LANES; l++)
        if (first[l] && addr[l*ADDR_W +: BW] == BW'(b))
          cnt = cnt + CNT_W'(1);
      if (cnt > degree) degree = cnt;
    end
  end
endmodule

// File: rtl/spad_pass_sel.sv
module spad_pass_sel #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  localparam int BW    = $clog2(BANKS),
  localparam int ROW_W = ADDR_W - BW
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [BANKS*ROW_W-1:0]  bank_row,
  output logic [LANES-1:0]        serve
);
  // Per bank: row of the lowest-numbered pending lane mapped to it
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_comb begin
      bank_row[b*ROW_W +: ROW_W] = '0;
      for (int l = LANES - 1; l >= 0; l--)
        if (pending[l] && addr[l*ADDR_W +: BW] == BW'(b))
          bank_row[b*ROW_W +: ROW_W] = addr[l*ADDR_W + BW +: ROW_W];
    end
  end

  // Every pending lane whose word matches its bank's pick is retired
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [BW-1:0] bk;
      bk = addr[l*ADDR_W +: BW];
      serve[l] = pending[l] &&
                 (bank_row[bk*ROW_W +: ROW_W] == addr[l*ADDR_W + BW +: ROW_W]);
    end
  end
endmodule

// File: rtl/spad_store.sv
module spad_store
  import spad_pkg::*;
#(
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  localparam int BW    = $clog2(BANKS),
  localparam int ROW_W = ADDR_W - BW,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BANKS*ROW_W-1:0]  rd_row,
  output logic [BANKS*WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [BANKS][DEPTH];

  // Storage is loaded with its image on reset; no write path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < DEPTH; r++)
          mem[b][r] <= image_word(32'(r * BANKS + b));
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_rd
    assign rd_data[b*WORD_W +: WORD_W] = mem[b][rd_row[b*ROW_W +: ROW_W]];
  end
endmodule

// File: rtl/spad_serializer.sv
module spad_serializer
  import spad_pkg::*;
#(
  parameter int LANES       = 32,
  parameter int BANKS       = 32,
  parameter int ADDR_W      = 10,
  parameter int PASS_CYCLES = 2,
  localparam int BW      = $clog2(BANKS),
  localparam int ROW_W   = ADDR_W - BW,
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int PHASE_W = $clog2(PASS_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    rsp_valid,
  output logic [CNT_W-1:0]        rsp_degree,
  output logic [LANES*WORD_W-1:0] rsp_data
);
  ser_state_e                state_q;
  logic [LANES-1:0]          act_q;
  logic [LANES-1:0]          pend_q;
  logic [LANES*ADDR_W-1:0]   addr_q;
  logic [PHASE_W-1:0]        phase_q;
  logic                      done_q;
  logic [LANES*WORD_W-1:0]   data_q;
  logic [LANES-1:0]          serve;
  logic [BANKS*ROW_W-1:0]    bank_row;
  logic [BANKS*WORD_W-1:0]   bank_data;
  logic                      accept;
  logic                      last_phase;

  assign req_ready  = (state_q == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign last_phase = (phase_q == PHASE_W'(PASS_CYCLES - 1));
  assign rsp_valid  = done_q;
  assign rsp_data   = data_q;

  spad_degree #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_degree (
    .act(act_q), .addr(addr_q), .degree(rsp_degree)
  );

  spad_pass_sel #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_sel (
    .pending(pend_q), .addr(addr_q), .bank_row(bank_row), .serve(serve)
  );

  spad_store #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_row(bank_row), .rd_data(bank_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      act_q   <= '0;
      pend_q  <= '0;
      addr_q  <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= S_BUSY;
        act_q   <= req_active;
        pend_q  <= req_active;
        addr_q  <= req_addr;
        phase_q <= '0;
        data_q  <= '0;
      end else if (state_q == S_BUSY) begin
        if (pend_q == '0) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end else if (last_phase) begin
          phase_q <= '0;
          pend_q  <= pend_q & ~serve;
          for (int l = 0; l < LANES; l++)
            if (serve[l])
              data_q[l*WORD_W +: WORD_W] <=
                bank_data[addr_q[l*ADDR_W +: BW]*WORD_W +: WORD_W];
        end else begin
          phase_q <= phase_q + PHASE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spad_serializer_chk.sv
module spad_serializer_chk
  import spad_pkg::*;
#(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic [CNT_W-1:0]        rsp_degree,
  input logic [LANES*WORD_W-1:0] rsp_data,
  input logic [LANES-1:0]        act_q
);
  logic stray;
  always_comb begin
    stray = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (!act_q[l] && rsp_data[l*WORD_W +: WORD_W] != '0) stray = 1'b1;
  end

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready));

  p_inactive_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !stray);

  p_empty_degree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((act_q == '0) == (rsp_degree == '0)));

  p_degree_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_degree <= CNT_W'(LANES)));
endmodule

bind spad_serializer spad_serializer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_degree(rsp_degree), .rsp_data(rsp_data),
  .act_q(act_q)
);

// File: tb/spad_serializer_test.sv
module spad_serializer_test;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int DW    = 32;

  typedef struct packed {
    logic [1:0]  kind;
    logic [9:0]  base;
    logic [9:0]  stride;
    logic [31:0] mask;
    logic [5:0]  deg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 10'd0,    10'd1,  32'hFFFFFFFF, 6'd1},   // R1 linear
    '{2'd0, 10'd77,   10'd0,  32'hFFFFFFFF, 6'd1},   // R3 broadcast
    '{2'd0, 10'd5,    10'd32, 32'hFFFFFFFF, 6'd32},  // R2 worst case
    '{2'd0, 10'd0,    10'd2,  32'hFFFFFFFF, 6'd2},
    '{2'd0, 10'd3,    10'd16, 32'hFFFFFFFF, 6'd16},
    '{2'd0, 10'd100,  10'd33, 32'hFFFFFFFF, 6'd1},   // R1 odd stride
    '{2'd0, 10'd1,    10'd4,  32'h0000FFFF, 6'd2},   // R5 half mask
    '{2'd1, 10'd7,    10'd0,  32'hFFFFFFFF, 6'd17},  // R3 mix
    '{2'd0, 10'd1020, 10'd1,  32'hFFFFFFFF, 6'd1},   // R1 wrap
    '{2'd0, 10'd0,    10'd64, 32'hAAAAAAAA, 6'd8}    // R2 shared+conflict
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [LANES-1:0]     req_active = '0;
  logic [LANES*AW-1:0]  req_addr = '0;
  logic                 rsp_valid;
  logic [5:0]           rsp_degree;
  logic [LANES*DW-1:0]  rsp_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  spad_serializer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_degree(rsp_degree), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] img(input logic [9:0] a);
    logic [31:0] m;
    m = {22'd0, a} * 32'h9E3779B1;
    return m ^ 32'h5A5A0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Issue one request and check degree, latency, data and pulse width
  task automatic run_req(input logic [LANES-1:0] act, input logic [LANES*AW-1:0] addr,
                         input int exp_deg, input bit spam);
    int n;
    bit bad;
    logic [31:0] got, want;
    @(negedge clk);
    req_valid  = 1'b1;
    req_active = act;
    req_addr   = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = spam;
    req_active = spam ? ~act : act;
    req_addr   = spam ? ~addr : addr;
    if (spam) check(req_ready == 1'b0, "R6 ready low while busy", {31'd0, req_ready}, 0);
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (spam && n >= 2 * exp_deg) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    check(n == 2 * exp_deg + 1, "R4 latency", n, 2 * exp_deg + 1);
    check(rsp_degree == 6'(exp_deg), "R2 degree", {26'd0, rsp_degree}, exp_deg);
    bad = 1'b0; got = '0; want = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] e;
      e = act[l] ? img(addr[l*AW +: AW]) : 32'd0;
      if (!bad && rsp_data[l*DW +: DW] != e) begin
        bad = 1'b1; got = rsp_data[l*DW +: DW]; want = e;
      end
    end
    check(!bad, spam ? "R6 data unaffected by ignored request" : "R3 R5 R7 lane data",
          got, want);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 single pulse", {31'd0, rsp_valid}, 0);
  endtask

  function automatic logic [LANES*AW-1:0] gen_addr(input vec_t v);
    logic [LANES*AW-1:0] a;
    for (int l = 0; l < LANES; l++) begin
      if (v.kind == 2'd1)
        a[l*AW +: AW] = (l % 2 == 0) ? v.base : AW'(v.base + 32 * l);
      else
        a[l*AW +: AW] = AW'(v.base + v.stride * l);
    end
    return a;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R8 ready in reset", {31'd0, req_ready}, 1);
    check(rsp_valid == 1'b0, "R8 no pulse in reset", {31'd0, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_data == '0, "R8 data zero after reset", rsp_data[31:0], 0);
    check(req_ready == 1'b1, "R8 ready after reset", {31'd0, req_ready}, 1);

    for (int i = 0; i < NV; i++)
      run_req(VEC[i].mask, gen_addr(VEC[i]), int'(VEC[i].deg), 1'b0);

    // R9 empty request
    run_req('0, gen_addr(VEC[0]), 0, 1'b0);

    // R6 busy with requests presented and ignored
    run_req('1, gen_addr(VEC[2]), 32, 1'b1);

    // R5 single lane active amid conflicts
    run_req(32'h0000_0100, gen_addr(VEC[2]), 1, 1'b0);

    finish_run();
  end
endmodule